// File: doc/BRIEF.md
# Cursor Position Counter with Two-Code Address Loader

This block keeps the screen position of a text cursor on a grid of 50 columns by 20 rows. The column section moves one step on each increment or decrement strobe. It carries into the row section when it wraps from the last column to column 0. It borrows from the row section when it wraps from column 0 to the last column. The row section also wraps at both ends. A home command sends the cursor to column 0, row 0.

An absolute position is written in two steps. A load command detect starts the sequence. The next received code, inverted bit by bit over its low 7 bits, becomes the column. The code after that, inverted in the same way, becomes the row. While the sequence waits for these two codes, a steering output stays high so that the surrounding decoder does not treat the codes as data or functions. If an inverted code falls outside the range of its section, it is dropped and that section keeps its old value. A single-cycle bell pulse marks the moment the column reaches 44 from 43 or the row reaches 19 from 18.

Top module: `cursor_addr`

## Requirements
- R1: After reset, col and row read 0, and both steer and bell are low.
- R2: An increment with no decrement adds 1 to col. From col 49 it sets col to 0 and adds 1 to row. From row 19 the row wraps to 0.
- R3: A decrement with no increment subtracts 1 from col. From col 0 it sets col to 49 and subtracts 1 from row. From row 0 the row becomes 19.
- R4: When lca is high while steer is low, steer is high from the next cycle. The first code_vld after that loads col with ~code[6:0]. The second code_vld loads row with ~code[6:0], and steer is low from the cycle after it.
- R5: steer stays high for the whole time the sequence waits, including idle cycles between the two codes. A code_vld while steer is low leaves col, row and steer unchanged.
- R6: An inverted code of 50 or more for the column step, or of 20 or more for the row step, is dropped. The section it targets keeps its value, and the sequence still moves on to its next step.
- R7: bell is high for exactly one cycle. That cycle is the first in which col shows 44 after showing 43, or row shows 19 after showing 18. At all other times bell is low.
- R8: A home command clears col and row to 0 on the next cycle. It overrides counting and loading for that cycle.
- R9: When inc and dec are high in the same cycle, col and row do not change.
- R10: In a cycle where steer is high and code_vld is high, inc and dec have no effect; only the load applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc | input | 1 | Advance the cursor by one position |
| dec | input | 1 | Move the cursor back by one position |
| home | input | 1 | Send the cursor to column 0, row 0 |
| lca | input | 1 | Load command detected; starts the two-code sequence |
| code_vld | input | 1 | Strobe for a received code |
| code | input | 7 | Received code |
| col | output | 6 | Column address, 0 to 49 |
| row | output | 5 | Row address, 0 to 19 |
| steer | output | 1 | High while received codes are steered into the cursor |
| bell | output | 1 | One-cycle pulse on the 43-to-44 column or 18-to-19 row step |

## Verification
The assertions assume that every input is a defined level from the first clock after reset, and that lca arrives only as a single-cycle strobe. The stimulus drives every input on the falling edge from one task, so each value is stable and known at the rising edge. The task raises lca for one cycle only, and it pairs code_vld with a defined code on every cycle. The counting sweeps start only from positions the block itself has reached, so col and row never leave their legal ranges before a check depends on them.

// File: rtl/cursor_addr.sv
module cursor_addr #(
  parameter int COLS     = 50,
  parameter int ROWS     = 20,
  parameter int CODEW    = 7,
  parameter int BELL_COL = 44,
  parameter int BELL_ROW = 19,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             home,
  input  logic             lca,
  input  logic             code_vld,
  input  logic [CODEW-1:0] code,
  output logic [CW-1:0]    col,
  output logic [RW-1:0]    row,
  output logic             steer,
  output logic             bell
);
  localparam logic [CW-1:0]    COL_MAX = CW'(COLS - 1);
  localparam logic [RW-1:0]    ROW_MAX = RW'(ROWS - 1);
  localparam logic [CODEW-1:0] COL_LIM = CODEW'(COLS);
  localparam logic [CODEW-1:0] ROW_LIM = CODEW'(ROWS);

  typedef enum logic [1:0] {IDLE, GET_COL, GET_ROW} ld_t;
  ld_t st, st_nxt;

  logic [CW-1:0]    col_nxt;
  logic [RW-1:0]    row_nxt;
  logic [CODEW-1:0] inv;
  logic             take, up, down;

  assign inv   = ~code;
  assign take  = (st != IDLE) && code_vld;
  assign up    = inc && !dec && !take;
  assign down  = dec && !inc && !take;
  assign steer = (st != IDLE);

  always_comb begin
    st_nxt = st;
    case (st)
      IDLE:    if (lca)      st_nxt = GET_COL;
      GET_COL: if (code_vld) st_nxt = GET_ROW;
      GET_ROW: if (code_vld) st_nxt = IDLE;
      default:               st_nxt = IDLE;
    endcase
  end

  always_comb begin
    col_nxt = col;
    row_nxt = row;
    if (home) begin
      col_nxt = '0;
      row_nxt = '0;
    end else if (take) begin
      if (st == GET_COL && inv < COL_LIM) col_nxt = inv[CW-1:0];
      if (st == GET_ROW && inv < ROW_LIM) row_nxt = inv[RW-1:0];
    end else if (up) begin
      if (col == COL_MAX) begin
        col_nxt = '0;
        row_nxt = (row == ROW_MAX) ? '0 : row + 1'b1;
      end else begin
        col_nxt = col + 1'b1;
      end
    end else if (down) begin
      if (col == '0) begin
        col_nxt = COL_MAX;
        row_nxt = (row == '0) ? ROW_MAX : row - 1'b1;
      end else begin
        col_nxt = col - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      col  <= '0;
      row  <= '0;
      bell <= 1'b0;
    end else begin
      st   <= st_nxt;
      col  <= col_nxt;
      row  <= row_nxt;
      bell <= (col == CW'(BELL_COL - 1) && col_nxt == CW'(BELL_COL)) ||
              (row == RW'(BELL_ROW - 1) && row_nxt == RW'(BELL_ROW));
    end
  end
endmodule

module cursor_addr_chk #(
  parameter int COLS     = 50,
  parameter int ROWS     = 20,
  parameter int CODEW    = 7,
  parameter int BELL_COL = 44,
  parameter int BELL_ROW = 19,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc,
  input logic             dec,
  input logic             home,
  input logic             lca,
  input logic             code_vld,
  input logic [CODEW-1:0] code,
  input logic [CW-1:0]    col,
  input logic [RW-1:0]    row,
  input logic             steer,
  input logic             bell
);
  logic quiet_count;
  assign quiet_count = !home && !(steer && code_vld);

  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col < CW'(COLS) && row < RW'(ROWS));

  assert_col_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !dec && quiet_count && col == CW'(COLS - 1) |=> col == '0);

  assert_col_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !inc && quiet_count && col == '0 |=> col == CW'(COLS - 1));

  assert_steer_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer) |-> $past(lca));

  assert_bell_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bell |-> (col == CW'(BELL_COL) && $past(col) == CW'(BELL_COL - 1)) ||
             (row == RW'(BELL_ROW) && $past(row) == RW'(BELL_ROW - 1)));

  assert_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> col == '0 && row == '0);

  assert_no_tie_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inc && dec && quiet_count |=> $stable(col) && $stable(row));
endmodule

bind cursor_addr cursor_addr_chk #(
  .COLS(COLS), .ROWS(ROWS), .CODEW(CODEW), .BELL_COL(BELL_COL), .BELL_ROW(BELL_ROW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .home(home), .lca(lca),
  .code_vld(code_vld), .code(code), .col(col), .row(row), .steer(steer), .bell(bell)
);

// File: tb/test_cursor_addr.sv
module test_cursor_addr;
  logic clk = 1'b0;
  logic rst_n, inc, dec, home, lca, code_vld;
  logic [6:0] code;
  logic [5:0] col;
  logic [4:0] row;
  logic steer, bell;

  int tests = 0, fails = 0;
  int mc = 0, mr = 0, ms = 0;

  always #5 clk = ~clk;

  cursor_addr i_cursor_addr (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .home(home), .lca(lca),
    .code_vld(code_vld), .code(code), .col(col), .row(row), .steer(steer), .bell(bell)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic i, input logic d, input logic h, input logic l,
                     input logic v, input logic [6:0] cd, input string tag);
    int oc = mc, orow = mr, nc = mc, nr = mr, ns = ms, cp;
    logic eb;
    cp = 127 - int'(cd);
    if (h) begin nc = 0; nr = 0; end
    else if (ms != 0 && v) begin
      if (ms == 1 && cp < 50) nc = cp;
      if (ms == 2 && cp < 20) nr = cp;
    end else if (i && !d) begin
      if (mc == 49) begin nc = 0; nr = (mr == 19) ? 0 : mr + 1; end
      else nc = mc + 1;
    end else if (d && !i) begin
      if (mc == 0) begin nc = 49; nr = (mr == 0) ? 19 : mr - 1; end
      else nc = mc - 1;
    end
    if (ms == 0 && l) ns = 1;
    else if (ms == 1 && v) ns = 2;
    else if (ms == 2 && v) ns = 0;
    eb = (oc == 43 && nc == 44) || (orow == 18 && nr == 19);
    inc = i; dec = d; home = h; lca = l; code_vld = v; code = cd;
    @(posedge clk);
    @(negedge clk);
    mc = nc; mr = nr; ms = ns;
    check(tag, int'(col), mc, "col");
    check(tag, int'(row), mr, "row");
    check(tag, int'(steer), (ms != 0) ? 1 : 0, "steer");
    check("R7", int'(bell), eb ? 1 : 0, "bell");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inc = 0; dec = 0; home = 0; lca = 0; code_vld = 0; code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", int'(col), 0, "col");
    check("R1", int'(row), 0, "row");
    check("R1", int'(steer), 0, "steer");
    check("R1", int'(bell), 0, "bell");

    // R2: full forward sweep through every position plus wrap
    for (int k = 0; k < 1001; k++) cyc(1, 0, 0, 0, 0, 7'h00, "R2");
    cyc(0, 0, 0, 0, 0, 7'h00, "R2");
    // R3: full backward sweep with borrows
    for (int k = 0; k < 1002; k++) cyc(0, 1, 0, 0, 0, 7'h00, "R3");
    // R9: tie at several positions, including the column and row edges
    for (int k = 0; k < 60; k++) begin
      cyc(1, 1, 0, 0, 0, 7'h00, "R9");
      cyc(1, 0, 0, 0, 0, 7'h00, "R2");
    end
    // R8: home overrides counting
    cyc(1, 0, 1, 0, 0, 7'h00, "R8");
    // R5: a code while idle changes nothing
    cyc(0, 0, 0, 0, 1, 7'h55, "R5");
    // R4/R6: every code value for the column step and for the row step
    for (int c = 0; c < 128; c++) begin
      cyc(0, 0, 0, 1, 0, 7'h00, "R4");
      cyc(0, 0, 0, 0, 0, 7'h00, "R5");
      cyc(0, 0, 0, 0, 1, 7'(c), (127 - c < 50) ? "R4" : "R6");
      cyc(0, 0, 0, 0, 0, 7'h00, "R5");
      cyc(0, 0, 0, 0, 1, 7'(c), (127 - c < 20) ? "R4" : "R6");
    end
    // R10: a count during the load cycle is ignored
    cyc(0, 0, 0, 1, 0, 7'h00, "R4");
    cyc(1, 0, 0, 0, 1, ~7'd43, "R10");
    cyc(0, 1, 0, 0, 1, ~7'd18, "R10");
    // R7: bell on the row 18-to-19 step via count and on the column step
    cyc(1, 0, 0, 0, 0, 7'h00, "R2");
    cyc(0, 0, 0, 0, 0, 7'h00, "R7");
    cyc(0, 0, 0, 1, 0, 7'h00, "R4");
    cyc(0, 0, 0, 0, 1, ~7'd49, "R4");
    cyc(0, 0, 0, 0, 1, ~7'd18, "R4");
    cyc(1, 0, 0, 0, 0, 7'h00, "R2");
    cyc(0, 0, 0, 0, 0, 7'h00, "R7");
    // R8: home during a pending load clears position, sequence continues
    cyc(0, 0, 0, 1, 0, 7'h00, "R4");
    cyc(0, 0, 1, 0, 1, ~7'd10, "R8");
    cyc(0, 0, 0, 0, 1, ~7'd3, "R4");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule